// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This unit does the arithmetic an 8-bit processor with 16-bit register pairs needs for increments, decrements, pair additions and stack-pointer offsets. Each operation takes a source value, a second operand and the current flag byte, and returns a result, a new flag byte and a request for one extra machine cycle. It also cleans the flag byte when the pair that holds the accumulator and flags is reloaded from the stack. The caller handles instruction fetch and any memory read-modify-write around the unit.

An operation is presented on `op_valid` with `op_sel`, `src`, `opnd` and `flags_in`. The outputs are registered and appear one clock later, marked by `res_valid`. When no operation is presented, the outputs hold their values.

Top module: `pair_arith_unit`

## Requirements
- R1: Flag byte layout is Z=bit 7, N=bit 6, H=bit 5, C=bit 4. For op_sel 0 (8-bit increment), result = {8'h00, src[7:0]+1 mod 256}. Z is set when that byte is zero, N is cleared, H is set when the result's low nibble is 0x0, and C keeps flags_in bit 4.
- R2: For op_sel 1 (8-bit decrement), result = {8'h00, src[7:0]-1 mod 256}. Z is set when that byte is zero, N is set, H is set when the result's low nibble is 0xF, and C keeps flags_in bit 4.
- R3: For op_sel 2 (16-bit increment) and op_sel 3 (16-bit decrement), result is src+1 or src-1 modulo 0x10000, and flags_out equals flags_in.
- R4: For op_sel 4 (16-bit add), result = src+opnd modulo 0x10000. Z keeps flags_in bit 7, N is cleared, H is the carry out of bit 11 and C is the carry out of bit 15.
- R5: For op_sel 5 (stack offset), result = src + sign-extended opnd[7:0] modulo 0x10000. Z and N are cleared, H is the unsigned carry out of bit 3 of src[7:0]+opnd[7:0], and C is the carry out of bit 7 of that sum.
- R6: For op_sel 6 (pair restore), result = {src[15:4], 4'h0} and flags_out = {src[7:4], 4'h0}.
- R7: extra_cycle is 1 after op_sel 2, 3, 4 or 5. It is 0 after op_sel 0, 1, 6 or 7, and 0 after any cycle without op_valid.
- R8: Outputs update one clock after op_valid is high, with res_valid high in that cycle. After a cycle without op_valid, res_valid is 0 and result and flags_out keep their previous values.
- R9: After reset, result, flags_out, extra_cycle and res_valid are all zero.
- R10: For op_sel 7 (reserved), result = src and flags_out = flags_in.
- R11: For every op_sel other than 6, flags_out[3:0] equals flags_in[3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (see R1-R6, R10) |
| src | input | 16 | Source value, pair or byte in the low half |
| opnd | input | 16 | Second operand or signed offset in the low byte |
| flags_in | input | 8 | Current flag byte |
| result | output | 16 | Registered result |
| flags_out | output | 8 | Registered new flag byte |
| extra_cycle | output | 1 | The operation needs one more machine cycle |
| res_valid | output | 1 | Outputs were updated in the previous cycle |

## Verification
The hardest cases to reach are the stack-offset flag cases. There, H and C come from the unsigned low-byte sum while the result itself uses a negative offset, so a carry flag can be set even though the 16-bit value went down. Random operands seldom produce the exact nibble and byte boundaries, so directed operands put src low bytes of 0x0F, 0xFF and 0x00 against offsets of 0x01 and 0xFF. Similar directed values sit at the bit-11 and bit-15 boundaries of the pair add, and at the 0x00, 0x0F, 0x10 and 0xFF wrap points of the byte increment and decrement.

// File: rtl/pair_arith_pkg.sv
package pair_arith_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 3;

  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef enum logic [OP_W-1:0] {
    OP_INC8    = 3'd0,
    OP_DEC8    = 3'd1,
    OP_INC16   = 3'd2,
    OP_DEC16   = 3'd3,
    OP_ADD16   = 3'd4,
    OP_SPOFS   = 3'd5,
    OP_RESTORE = 3'd6,
    OP_RSVD    = 3'd7
  } op_e;

  // Carry out of bit position msb when adding the bits msb..0 of a and b.
  function automatic logic carry_out(input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b,
                                     input int unsigned msb);
    logic [WORD_W:0] mask;
    logic [WORD_W:0] sum;
    mask = (({{WORD_W{1'b0}}, 1'b1}) << (msb + 1)) - 1'b1;
    sum  = ({1'b0, a} & mask) + ({1'b0, b} & mask);
    return sum[msb+1];
  endfunction

  function automatic logic [WORD_W-1:0] sext_byte(input logic [BYTE_W-1:0] v);
    return {{(WORD_W-BYTE_W){v[BYTE_W-1]}}, v};
  endfunction

  function automatic logic needs_extra(input op_e op);
    return (op == OP_INC16) || (op == OP_DEC16) ||
           (op == OP_ADD16) || (op == OP_SPOFS);
  endfunction
endpackage

// File: rtl/pair_arith_byte.sv
module pair_arith_byte
  import pair_arith_pkg::*;
(
  input  logic              is_dec,
  input  logic [BYTE_W-1:0] value,
  input  logic [BYTE_W-1:0] flags_in,
  output logic [BYTE_W-1:0] res8,
  output logic [BYTE_W-1:0] flags8
);
  logic [NIB_W-1:0] low_nib;

  always_comb begin
    res8    = is_dec ? (value - 1'b1) : (value + 1'b1);
    low_nib = res8[NIB_W-1:0];
    flags8  = flags_in;
    flags8[FLAG_Z] = (res8 == '0);
    flags8[FLAG_N] = is_dec;
    flags8[FLAG_H] = is_dec ? (low_nib == {NIB_W{1'b1}}) : (low_nib == '0);
  end
endmodule

// File: rtl/pair_arith_word.sv
module pair_arith_word
  import pair_arith_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [BYTE_W-1:0] flags_in,
  output logic [WORD_W-1:0] res16,
  output logic [BYTE_W-1:0] flags16
);
  logic [WORD_W-1:0] offset;
  logic              add_h, add_c, ofs_h, ofs_c;

  assign offset = sext_byte(b[BYTE_W-1:0]);
  assign add_h  = carry_out(a, b, 11);
  assign add_c  = carry_out(a, b, WORD_W-1);
  assign ofs_h  = carry_out(a, b, NIB_W-1);
  assign ofs_c  = carry_out(a, b, BYTE_W-1);

  always_comb begin
    res16   = a;
    flags16 = flags_in;
    case (op)
      OP_INC16: res16 = a + 1'b1;
      OP_DEC16: res16 = a - 1'b1;
      OP_ADD16: begin
        res16 = a + b;
        flags16[FLAG_N] = 1'b0;
        flags16[FLAG_H] = add_h;
        flags16[FLAG_C] = add_c;
      end
      OP_SPOFS: begin
        res16 = a + offset;
        flags16[FLAG_Z] = 1'b0;
        flags16[FLAG_N] = 1'b0;
        flags16[FLAG_H] = ofs_h;
        flags16[FLAG_C] = ofs_c;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
  import pair_arith_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] opnd,
  input  logic [BYTE_W-1:0] flags_in,
  output logic [WORD_W-1:0] result,
  output logic [BYTE_W-1:0] flags_out,
  output logic              extra_cycle,
  output logic              res_valid
);
  op_e               op;
  logic [BYTE_W-1:0] r8, f8, f16;
  logic [WORD_W-1:0] r16;
  logic [WORD_W-1:0] next_res;
  logic [BYTE_W-1:0] next_flags;
  logic              next_extra;
  logic              is_byte_op, is_word_op, is_restore;

  assign op         = op_e'(op_sel);
  assign is_byte_op = (op == OP_INC8) || (op == OP_DEC8);
  assign is_word_op = needs_extra(op);
  assign is_restore = (op == OP_RESTORE);

  pair_arith_byte u_byte (
    .is_dec   (op == OP_DEC8),
    .value    (src[BYTE_W-1:0]),
    .flags_in (flags_in),
    .res8     (r8),
    .flags8   (f8)
  );

  pair_arith_word u_word (
    .op       (op),
    .a        (src),
    .b        (opnd),
    .flags_in (flags_in),
    .res16    (r16),
    .flags16  (f16)
  );

  always_comb begin
    next_extra = is_word_op;
    if (is_byte_op) begin
      next_res   = {{(WORD_W-BYTE_W){1'b0}}, r8};
      next_flags = f8;
    end else if (is_word_op) begin
      next_res   = r16;
      next_flags = f16;
    end else if (is_restore) begin
      next_res   = {src[WORD_W-1:NIB_W], {NIB_W{1'b0}}};
      next_flags = {src[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
    end else begin
      next_res   = src;
      next_flags = flags_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result      <= '0;
      flags_out   <= '0;
      extra_cycle <= 1'b0;
      res_valid   <= 1'b0;
    end else begin
      res_valid   <= op_valid;
      extra_cycle <= op_valid && next_extra;
      if (op_valid) begin
        result    <= next_res;
        flags_out <= next_flags;
      end
    end
  end

  // R3
  wide_step_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == OP_INC16 || op == OP_DEC16) |=> flags_out == $past(flags_in));

  // R1
  byte_carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_byte_op |=> flags_out[FLAG_C] == $past(flags_in[FLAG_C]));

  // R5
  offset_zn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_SPOFS |=> !flags_out[FLAG_Z] && !flags_out[FLAG_N]);

  // R6
  restore_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_restore |=> flags_out[NIB_W-1:0] == '0 && result[NIB_W-1:0] == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && !extra_cycle && $stable(result) && $stable(flags_out));

  // R7
  extra_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> extra_cycle == ($past(op_sel) >= 3'd2 && $past(op_sel) <= 3'd5));

  // R4
  add_z_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_ADD16 |=> flags_out[FLAG_Z] == $past(flags_in[FLAG_Z]));
endmodule

// File: tb/test_pair_arith_unit.sv
module test_pair_arith_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [15:0] src = '0;
  logic [15:0] opnd = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] result;
  logic [7:0]  flags_out;
  logic        extra_cycle;
  logic        res_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_arith_unit i_pair_arith_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src(src), .opnd(opnd), .flags_in(flags_in), .result(result),
    .flags_out(flags_out), .extra_cycle(extra_cycle), .res_valid(res_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2, 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; default: return "R10";
    endcase
  endfunction

  function automatic int model_res(input int op, input int s, input int b);
    int off;
    case (op)
      0: return ((s & 255) + 1) & 255;
      1: return ((s & 255) + 255) & 255;
      2: return (s + 1) & 65535;
      3: return (s + 65535) & 65535;
      4: return (s + b) & 65535;
      5: begin
        off = b & 255;
        if (off >= 128) off = off - 256;
        return (s + off + 65536) & 65535;
      end
      6: return s & 65520;
      default: return s;
    endcase
  endfunction

  function automatic int model_flags(input int op, input int s, input int b, input int f);
    int r, z, n, h, c;
    r = model_res(op, s, b);
    z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
    case (op)
      0: begin z = (r == 0); n = 0; h = ((r % 16) == 0); end
      1: begin z = (r == 0); n = 1; h = ((r % 16) == 15); end
      4: begin n = 0; h = ((s % 4096) + (b % 4096)) > 4095; c = (s + b) > 65535; end
      5: begin z = 0; n = 0; h = ((s % 16) + (b % 16)) > 15; c = ((s % 256) + (b % 256)) > 255; end
      6: return s & 240;
      default: ;
    endcase
    return (z << 7) | (n << 6) | (h << 5) | (c << 4) | (f & 15);
  endfunction

  task automatic run_op(input int op, input int s, input int b, input int f);
    int er, ef, ex;
    @(negedge clk);
    op_valid = 1'b1; op_sel = 3'(op); src = 16'(s); opnd = 16'(b); flags_in = 8'(f);
    er = model_res(op, s, b);
    ef = model_flags(op, s, b, f);
    ex = (op >= 2 && op <= 5) ? 1 : 0;
    @(negedge clk);
    op_valid = 1'b0;
    check({req_of(op), " result"}, int'(result), er);
    check({req_of(op), " flags"}, int'(flags_out), ef);
    if (op != 6) check("R11 low flag nibble", int'(flags_out) & 15, f & 15);
    check("R7 extra_cycle", int'(extra_cycle), ex);
    check("R8 res_valid", int'(res_valid), 1);
  endtask

  task automatic idle_check();
    int pr, pf;
    pr = int'(result); pf = int'(flags_out);
    @(negedge clk);
    op_valid = 1'b0; op_sel = 3'($urandom_range(7)); src = 16'($urandom);
    opnd = 16'($urandom); flags_in = 8'($urandom);
    @(negedge clk);
    check("R8 idle result held", int'(result), pr);
    check("R8 idle flags held", int'(flags_out), pf);
    check("R8 idle res_valid", int'(res_valid), 0);
    check("R7 idle extra_cycle", int'(extra_cycle), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R9 reset result", int'(result), 0);
    check("R9 reset flags", int'(flags_out), 0);
    check("R9 reset extra", int'(extra_cycle), 0);
    check("R9 reset valid", int'(res_valid), 0);
    rst_n = 1'b1;
    // directed corners
    run_op(0, 16'h12FF, 0, 8'h1A);
    run_op(0, 16'h000F, 0, 8'h00);
    run_op(0, 16'h0010, 0, 8'hF0);
    run_op(1, 16'h0001, 0, 8'h10);
    run_op(1, 16'h0010, 0, 8'h00);
    run_op(1, 16'h0000, 0, 8'h05);
    run_op(2, 16'hFFFF, 0, 8'hB3);
    run_op(3, 16'h0000, 0, 8'h4C);
    run_op(4, 16'h0FFF, 16'h0001, 8'h80);
    run_op(4, 16'h8000, 16'h8000, 8'h00);
    run_op(4, 16'hFFFF, 16'hFFFF, 8'h7F);
    run_op(5, 16'h000F, 16'h0001, 8'hC0);
    run_op(5, 16'h00FF, 16'h0001, 8'h00);
    run_op(5, 16'h1000, 16'h00FF, 8'hFF);
    run_op(5, 16'h0001, 16'h00FF, 8'h00);
    run_op(6, 16'h12FF, 0, 8'h00);
    run_op(7, 16'hABCD, 16'h1111, 8'h96);
    idle_check();
    for (int i = 0; i < 400; i++) begin
      run_op($urandom_range(7), $urandom_range(65535), $urandom_range(65535),
             $urandom_range(255));
      if (i % 37 == 0) idle_check();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule